// File: doc/BRIEF.md
# Drift-Prone Symbol Parity Gate

This block sits in front of the error-correction path of a multi-level-cell memory whose cells each hold a 2-bit symbol as one of four resistance levels. Some of those levels drift toward a neighbouring level over time, so a line holding many such symbols is at risk of soft errors. When a line is written, the block counts how many of its symbols are in a drift-prone code and turns that count into a one-bit parity flag. The memory controller stores this flag next to the line.

During each periodic light scrub read, the controller presents the line contents again together with the flag it stored. The block recounts the drift-prone symbols and compares the new parity with the stored flag. If they differ, a symbol has probably moved to another level, and the block asks for a full ECC check. If they agree, no request is made, so the costly decode is skipped in the common case. Only the parity of the count is ever formed: it is an XOR tree over one match bit per symbol. The set of drift-prone codes is a 4-bit mask parameter.

Top module: `drift_parity_gate`

## Requirements
- R1: Symbol i of `lineData` occupies bits [2i+1:2i], and its code is that 2-bit value. A symbol is drift-prone when bit `code` of the parameter `DRIFT_MASK` is 1. The default mask is 4'b0110, which makes codes 01 and 10 drift-prone and codes 00 and 11 stable.
- R2: When `writeStb` is high at a rising edge, `newFlag` holds after that edge the parity of the drift-prone count: 0 for even, 1 for odd. `flagValid` is high for exactly that one cycle.
- R3: `newFlag` keeps its value across every edge at which `writeStb` is low.
- R4: When `checkStb` is high at a rising edge, `checkValid` is high for the one cycle that follows.
- R5: In a cycle where `checkValid` is high, `eccRequest` is 1 if the recomputed parity differs from the `storedFlag` sampled with the strobe, and 0 if they match.
- R6: After an edge with no strobe, `flagValid`, `checkValid` and `eccRequest` are all 0. `eccRequest` is never high without `checkValid`.
- R7: If both strobes are high at the same edge, both actions take place. The check compares against `storedFlag`, not against the flag being written.
- R8: While `rstN` is low, all outputs are 0.
- R9: A line with no drift-prone symbol gives flag 0. A line made only of drift-prone symbols gives the parity of `NUM_SYM`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineData | input | 2*NUM_SYM | Line contents, one 2-bit symbol per cell |
| writeStb | input | 1 | Line is being written; compute a new flag |
| checkStb | input | 1 | Light scrub read; compare with the stored flag |
| storedFlag | input | 1 | Flag kept with the line since its last write |
| newFlag | output | 1 | Flag to store with the written line |
| flagValid | output | 1 | One-cycle pulse after a write strobe |
| checkValid | output | 1 | One-cycle pulse after a check strobe |
| eccRequest | output | 1 | Full ECC check required (valid with checkValid) |

## Verification
The bench builds the block with `NUM_SYM` = 8 and the default mask. At that width, lines with every drift-prone count from zero to all eight symbols can be reached by directed patterns as well as by random ones. An even full-line count gives flag 0, so an all-01 line and an all-00 line must both give 0, while a single 10 symbol among 11s must give 1. Eight symbols also make the XOR tree three levels deep, with no padded leaves, and random lines with random stored flags drive both the match and mismatch outcomes many times.

// File: rtl/drift_pkg.sv
package drift_pkg;

  // Strobes passed from control to datapath in the same cycle.
  typedef struct packed {
    logic loadFlag;
    logic runCheck;
  } ctrlStrobes_t;

endpackage

// File: rtl/drift_sym_match.sv
module drift_sym_match #(
  parameter int unsigned NUM_SYM    = 16,
  parameter logic [3:0]  DRIFT_MASK = 4'b0110
) (
  input  logic [2*NUM_SYM-1:0] lineData,
  output logic                 parityOut
);

  localparam int unsigned LEVELS = (NUM_SYM > 1) ? $clog2(NUM_SYM) : 0;
  localparam int unsigned PAD    = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * PAD - 1;

  logic [NUM_SYM-1:0] matchBits;
  logic               node [0:NODES-1];

  // One match bit per symbol, chosen by the mask bit the code points at.
  for (genvar s = 0; s < NUM_SYM; s++) begin : g_match
    logic [1:0] symCode;
    assign symCode      = lineData[2*s +: 2];
    assign matchBits[s] = DRIFT_MASK[symCode];
  end

  // Leaves of the tree; padding leaves are zero.
  for (genvar l = 0; l < PAD; l++) begin : g_leaf
    if (l < NUM_SYM) begin : g_real
      assign node[PAD-1+l] = matchBits[l];
    end else begin : g_pad
      assign node[PAD-1+l] = 1'b0;
    end
  end

  // Internal nodes of a heap-ordered XOR tree.
  for (genvar n = 0; n < PAD - 1; n++) begin : g_node
    assign node[n] = node[2*n+1] ^ node[2*n+2];
  end

  assign parityOut = node[0];

  // R2: the tree result equals the low bit of a plain population count.
  always_comb begin
    if (!$isunknown(lineData)) begin
      p_tree_parity_r2: assert (parityOut == 1'(($countones(matchBits)) % 2))
        else $error("XOR tree parity disagrees with match count");
    end
  end

endmodule

// File: rtl/drift_ctrl.sv
module drift_ctrl
  import drift_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         writeStb,
  input  logic         checkStb,
  output ctrlStrobes_t strobes,
  output logic         flagValid,
  output logic         checkValid
);

  assign strobes.loadFlag = writeStb;
  assign strobes.runCheck = checkStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagValid  <= 1'b0;
      checkValid <= 1'b0;
    end else begin
      flagValid  <= writeStb;
      checkValid <= checkStb;
    end
  end

  // R2: a write strobe is always acknowledged in the next cycle.
  p_write_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    writeStb |=> flagValid);

endmodule

// File: rtl/drift_datapath.sv
module drift_datapath
  import drift_pkg::*;
#(
  parameter int unsigned NUM_SYM    = 16,
  parameter logic [3:0]  DRIFT_MASK = 4'b0110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [2*NUM_SYM-1:0] lineData,
  input  logic                 storedFlag,
  output logic                 newFlag,
  output logic                 eccRequest
);

  logic lineParity;

  drift_sym_match #(
    .NUM_SYM   (NUM_SYM),
    .DRIFT_MASK(DRIFT_MASK)
  ) u_match (
    .lineData (lineData),
    .parityOut(lineParity)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newFlag    <= 1'b0;
      eccRequest <= 1'b0;
    end else begin
      if (strobes.loadFlag) begin
        newFlag <= lineParity;
      end
      eccRequest <= strobes.runCheck && (lineParity != storedFlag);
    end
  end

  // R3: the flag register moves only on a write strobe.
  p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadFlag) |-> $stable(newFlag));

  // R6: no ECC request without a check in the previous cycle.
  p_no_idle_ecc_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.runCheck) |-> !eccRequest);

endmodule

// File: rtl/drift_parity_gate.sv
module drift_parity_gate
  import drift_pkg::*;
#(
  parameter int unsigned NUM_SYM    = 16,
  parameter logic [3:0]  DRIFT_MASK = 4'b0110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*NUM_SYM-1:0] lineData,
  input  logic                 writeStb,
  input  logic                 checkStb,
  input  logic                 storedFlag,
  output logic                 newFlag,
  output logic                 flagValid,
  output logic                 checkValid,
  output logic                 eccRequest
);

  ctrlStrobes_t strobes;

  drift_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .writeStb  (writeStb),
    .checkStb  (checkStb),
    .strobes   (strobes),
    .flagValid (flagValid),
    .checkValid(checkValid)
  );

  drift_datapath #(
    .NUM_SYM   (NUM_SYM),
    .DRIFT_MASK(DRIFT_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .lineData  (lineData),
    .storedFlag(storedFlag),
    .newFlag   (newFlag),
    .eccRequest(eccRequest)
  );

  // R5/R6: a request from the datapath lines up with the control's valid.
  p_ecc_needs_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    eccRequest |-> checkValid);

endmodule

// File: tb/drift_parity_gate_bench.sv
`timescale 1ns/1ps
module drift_parity_gate_bench;

  localparam int unsigned NSYM = 8;
  localparam logic [3:0]  MASK = 4'b0110;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [2*NSYM-1:0] lineData = '0;
  logic            writeStb = 1'b0;
  logic            checkStb = 1'b0;
  logic            storedFlag = 1'b0;
  logic            newFlag, flagValid, checkValid, eccRequest;

  int checks = 0;
  int fails  = 0;

  // Model state
  logic expFlag = 1'b0, expFv = 1'b0, expCv = 1'b0, expEcc = 1'b0;

  always #2.5 clk = ~clk;

  drift_parity_gate #(.NUM_SYM(NSYM), .DRIFT_MASK(MASK)) u_drift_parity_gate (
    .clk(clk), .rstN(rstN), .lineData(lineData), .writeStb(writeStb),
    .checkStb(checkStb), .storedFlag(storedFlag), .newFlag(newFlag),
    .flagValid(flagValid), .checkValid(checkValid), .eccRequest(eccRequest)
  );

  // Behavioural reference: count drift-prone codes one by one.
  function automatic int driftCount(logic [2*NSYM-1:0] d);
    int cnt = 0;
    for (int i = 0; i < NSYM; i++) begin
      int code = int'(d[2*i +: 2]);
      if (((int'(MASK) >> code) & 1) == 1) cnt++;
    end
    return cnt;
  endfunction

  task automatic chk(string req, string sig, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, sig, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare at negedge.
  task automatic step(logic [2*NSYM-1:0] d, logic w, logic c, logic sf, string tag);
    logic p;
    lineData = d; writeStb = w; checkStb = c; storedFlag = sf;
    @(posedge clk);
    p = logic'(driftCount(d) % 2);
    if (w) expFlag = p;
    expFv  = w;
    expCv  = c;
    expEcc = c && (p != sf);
    @(negedge clk);
    chk(w ? {"R2 ", tag} : {"R3 ", tag}, "newFlag",    newFlag,    expFlag);
    chk(w ? {"R2 ", tag} : {"R6 ", tag}, "flagValid",  flagValid,  expFv);
    chk(c ? {"R4 ", tag} : {"R6 ", tag}, "checkValid", checkValid, expCv);
    chk(c ? {"R5 ", tag} : {"R6 ", tag}, "eccRequest", eccRequest, expEcc);
  endtask

  // Build a line with every symbol equal to one code.
  function automatic logic [2*NSYM-1:0] fill(logic [1:0] code);
    logic [2*NSYM-1:0] d;
    for (int i = 0; i < NSYM; i++) d[2*i +: 2] = code;
    return d;
  endfunction

  initial begin
    logic [2*NSYM-1:0] d;
    repeat (3) @(negedge clk);
    // R8: outputs cleared in reset
    chk("R8", "newFlag",    newFlag,    1'b0);
    chk("R8", "flagValid",  flagValid,  1'b0);
    chk("R8", "checkValid", checkValid, 1'b0);
    chk("R8", "eccRequest", eccRequest, 1'b0);
    rstN = 1'b1;

    // R9: no drift-prone symbols, then all drift-prone (count 8, even)
    step(fill(2'b00), 1'b1, 1'b0, 1'b0, "R9 all00");
    step(fill(2'b11), 1'b1, 1'b0, 1'b0, "R9 all11");
    step(fill(2'b01), 1'b1, 1'b0, 1'b0, "R9 all01");
    // R1: symbol position and code mapping, single 10 at the top symbol
    d = fill(2'b11); d[2*NSYM-1 -: 2] = 2'b10;
    step(d, 1'b1, 1'b0, 1'b0, "R1 top10");
    // R3: idle cycles keep the flag of 1
    step(fill(2'b01), 1'b0, 1'b0, 1'b0, "R3 idle");
    step(fill(2'b00), 1'b0, 1'b0, 1'b1, "R3 idle");
    // R1: single 01 at symbol 0, code 11 elsewhere
    d = fill(2'b11); d[1:0] = 2'b01;
    step(d, 1'b1, 1'b0, 1'b0, "R1 low01");
    // R5: checks matching and mismatching
    step(d, 1'b0, 1'b1, 1'b1, "R5 match");
    step(d, 1'b0, 1'b1, 1'b0, "R5 mismatch");
    step(fill(2'b10), 1'b0, 1'b1, 1'b0, "R5 match even");
    step(fill(2'b10), 1'b0, 1'b1, 1'b1, "R5 mismatch even");
    // R7: both strobes, check against storedFlag not the new flag
    step(d, 1'b1, 1'b1, 1'b0, "R7 both");
    step(fill(2'b00), 1'b1, 1'b1, 1'b1, "R7 both");
    step(fill(2'b00), 1'b0, 1'b0, 1'b0, "R6 quiet");

    // Random traffic
    for (int k = 0; k < 400; k++) begin
      step(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "rand");
    end

    // R8: reset in the middle clears outputs
    step(d, 1'b1, 1'b1, 1'b0, "pre-reset");
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "newFlag",    newFlag,    1'b0);
    chk("R8", "eccRequest", eccRequest, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule